// File: doc/BRIEF.md
# Supply Startup and Protection Supervisor

This block is the mode controller of a switching power supply controller. It sees the supply rail, the rectified line and an external shutdown pin only as digital comparator flags, one flag per threshold. From these it decides when the pulse-width modulator may switch and when the high-voltage startup current source charges the supply capacitor. It also drives the transistor that discharges the rail when a fault is latched.

After the supply first reaches its start level, switching waits until the line is qualified. A long line sag suspends switching. A supply overvoltage, or a low level on the external shutdown pin, that lasts long enough latches the controller off. While switching is suspended, the startup source keeps the rail inside a band that depends on the mode. Only a supply drop to the stop level clears a latched fault. An overload timer outside this block can request an auto-restart wait. During that wait switching pauses and the rail is held in the wide band.

Top module: `supply_supervisor`

## Requirements
- R1: After reset the block is in OFF (state_oh = 6'b000001), hv_src_en is 1 and clamp_dis, pwm_run and fault_latched are 0.
- R2: In OFF, the block moves to STARTUP once vcc_ge_start (rail at or above 18 V) is seen and vcc_le_stop is low. From STARTUP it enters RUN once line_ge_bi (line at or above 104 V) is seen. In RUN without a restart request, pwm_run is 1 and hv_src_en is 0.
- R3: In STARTUP pwm_run stays 0 for as long as the line is not qualified.
- R4: In RUN, if line_le_bo (line at or below 99 V) holds for BO_CYC consecutive clocks after filtering, the block enters BROWNOUT_WAIT with pwm_run 0. A shorter sag has no effect. From BROWNOUT_WAIT, line_ge_bi returns the block to RUN.
- R5: STARTUP, BROWNOUT_WAIT and RUN with a restart request use the wide band. hv_src_en turns on when vcc_le_band_lo (rail at or below 15.5 V) is seen and turns off when vcc_ge_start is seen. Between the two levels it keeps its value.
- R6: While restart_req is high in RUN, pwm_run is 0 and the wide band applies. When restart_req drops, pwm_run returns to 1 with hv_src_en 0.
- R7: vcc_ge_ovp (rail above 26 V) held for FILT_CYC clocks latches a fault from STARTUP, RUN or BROWNOUT_WAIT. A shorter excursion has no effect.
- R8: lat_pin_low (shutdown pin at or below 1.05 V) is filtered by the same FILT_CYC window and latches a fault in the same states.
- R9: A latched fault enters LATCHED_CLAMP with clamp_dis 1, hv_src_en 0, pwm_run 0 and fault_latched 1. When vcc_le_clamp (rail at or below 14.5 V) is seen, the block moves to LATCHED_HOLD. The clamp is not driven again before the fault is cleared.
- R10: In LATCHED_HOLD, hv_src_en turns on when vcc_le_hold_lo (rail at or below 12 V) is seen and turns off when vcc_ge_hold_hi (rail at or above 13 V) is seen. Between the two levels it keeps its value.
- R11: vcc_le_stop (rail at or below 9.8 V) returns the block from any state to OFF and clears fault_latched. This takes priority over every other transition in the same cycle. In OFF, the fault sources are ignored.
- R12: state_oh is one-hot, with bit 0 OFF, bit 1 STARTUP, bit 2 RUN, bit 3 BROWNOUT_WAIT, bit 4 LATCHED_CLAMP and bit 5 LATCHED_HOLD.
- R13: Every comparator flag takes effect only after two equal consecutive samples, so a one-clock pulse on any flag is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ge_start | input | 1 | Rail at or above the start level (18 V) |
| vcc_le_stop | input | 1 | Rail at or below the stop level (9.8 V) |
| vcc_ge_ovp | input | 1 | Rail above the overvoltage level (26 V) |
| vcc_le_clamp | input | 1 | Rail at or below the clamp target (14.5 V) |
| vcc_le_band_lo | input | 1 | Rail at or below the wide-band floor (15.5 V) |
| vcc_le_hold_lo | input | 1 | Rail at or below the latch-band floor (12 V) |
| vcc_ge_hold_hi | input | 1 | Rail at or above the latch-band ceiling (13 V) |
| line_ge_bi | input | 1 | Line at or above the qualify level (104 V) |
| line_le_bo | input | 1 | Line at or below the sag level (99 V) |
| lat_pin_low | input | 1 | External shutdown pin at or below 1.05 V |
| restart_req | input | 1 | Auto-restart wait request from the overload timer |
| hv_src_en | output | 1 | Enable for the high-voltage startup current source |
| clamp_dis | output | 1 | Drive for the one-time rail discharge clamp |
| pwm_run | output | 1 | Permission for the modulator to switch |
| fault_latched | output | 1 | A fault is latched |
| state_oh | output | 6 | One-hot mode status |

## Verification
Two events can land in the same clock. The clamp discharge can end just as the rail collapses through the stop level. The bench provokes this by holding the block in LATCHED_CLAMP at a high rail and then stepping the rail straight to 9 V. That step raises vcc_le_clamp and vcc_le_stop on the same edge, and the bench expects OFF with the fault cleared, not LATCHED_HOLD. A second pairing is a short excursion on a fault source or on the line while the block is in RUN. Each such event must leave pwm_run unchanged, and each is judged against a long excursion of the same kind that must take effect.

// File: rtl/supsup_pkg.sv
package supsup_pkg;
  typedef enum logic [2:0] {
    S_OFF    = 3'd0,
    S_START  = 3'd1,
    S_RUN    = 3'd2,
    S_BOWAIT = 3'd3,
    S_CLAMP  = 3'd4,
    S_HOLD   = 3'd5
  } sup_state_e;

  typedef enum logic [1:0] {
    BAND_FORCE_ON  = 2'd0,
    BAND_FORCE_OFF = 2'd1,
    BAND_WIDE      = 2'd2,
    BAND_HOLD      = 2'd3
  } band_mode_e;

  localparam int NSTATE = 6;
  localparam int NFLAG  = 10;

  localparam int F_START   = 0;
  localparam int F_STOP    = 1;
  localparam int F_OVP     = 2;
  localparam int F_CLAMP   = 3;
  localparam int F_BANDLO  = 4;
  localparam int F_HOLDLO  = 5;
  localparam int F_HOLDHI  = 6;
  localparam int F_LINEBI  = 7;
  localparam int F_LINEBO  = 8;
  localparam int F_LATLOW  = 9;
endpackage

// File: rtl/flag_debounce.sv
module flag_debounce #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  logic [W-1:0] s0, s1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        s0[i]    <= 1'b0;
        s1[i]    <= 1'b0;
        clean[i] <= 1'b0;
      end else begin
        s0[i] <= raw[i];
        s1[i] <= s0[i];
        if (s0[i] == s1[i]) clean[i] <= s1[i];
      end
    end

    // R13: the filtered value only moves toward a value seen on two samples
    a_r13_two_samples: assert property (@(posedge clk) disable iff (rst)
      (clean[i] != $past(clean[i])) |-> ($past(s0[i]) == $past(s1[i])));
  end
endmodule

// File: rtl/persist_timer.sv
module persist_timer #(
  parameter int CYC = 16250
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cond,
  output logic trip
);
  localparam int CW = (CYC > 1) ? $clog2(CYC + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || !cond) begin
      cnt  <= '0;
      trip <= 1'b0;
    end else if (cnt == LAST) begin
      trip <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7 R8 R4: a trip only follows a qualified, enabled condition
  a_r7_trip_needs_cond: assert property (@(posedge clk) disable iff (rst)
    trip |-> ($past(cond) && $past(en)));
endmodule

// File: rtl/supply_band_reg.sv
module supply_band_reg
  import supsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  band_mode_e mode,
  input  logic       wide_lo,
  input  logic       wide_hi,
  input  logic       hold_lo,
  input  logic       hold_hi,
  output logic       src_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_en <= 1'b1;
    end else begin
      unique case (mode)
        BAND_FORCE_ON:  src_en <= 1'b1;
        BAND_FORCE_OFF: src_en <= 1'b0;
        BAND_WIDE: begin
          if (wide_lo)      src_en <= 1'b1;
          else if (wide_hi) src_en <= 1'b0;
        end
        BAND_HOLD: begin
          if (hold_lo)      src_en <= 1'b1;
          else if (hold_hi) src_en <= 1'b0;
        end
        default:        src_en <= 1'b0;
      endcase
    end
  end

  // R10: latch band charges once the rail is at its floor
  a_r10_hold_floor: assert property (@(posedge clk) disable iff (rst)
    (mode == BAND_HOLD && hold_lo) |=> src_en);
  // R5: wide band stops charging at the top of the band
  a_r5_wide_ceiling: assert property (@(posedge clk) disable iff (rst)
    (mode == BAND_WIDE && wide_hi && !wide_lo) |=> !src_en);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsup_pkg::*;
#(
  parameter int FILT_CYC = 16250,
  parameter int BO_CYC   = 12500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_ge_start,
  input  logic       vcc_le_stop,
  input  logic       vcc_ge_ovp,
  input  logic       vcc_le_clamp,
  input  logic       vcc_le_band_lo,
  input  logic       vcc_le_hold_lo,
  input  logic       vcc_ge_hold_hi,
  input  logic       line_ge_bi,
  input  logic       line_le_bo,
  input  logic       lat_pin_low,
  input  logic       restart_req,
  output logic       hv_src_en,
  output logic       clamp_dis,
  output logic       pwm_run,
  output logic       fault_latched,
  output logic [5:0] state_oh
);
  logic [NFLAG-1:0] raw, flt;

  always_comb begin
    raw           = '0;
    raw[F_START]  = vcc_ge_start;
    raw[F_STOP]   = vcc_le_stop;
    raw[F_OVP]    = vcc_ge_ovp;
    raw[F_CLAMP]  = vcc_le_clamp;
    raw[F_BANDLO] = vcc_le_band_lo;
    raw[F_HOLDLO] = vcc_le_hold_lo;
    raw[F_HOLDHI] = vcc_ge_hold_hi;
    raw[F_LINEBI] = line_ge_bi;
    raw[F_LINEBO] = line_le_bo;
    raw[F_LATLOW] = lat_pin_low;
  end

  flag_debounce #(.W(NFLAG)) u_deb (
    .clk(clk), .rst(rst), .raw(raw), .clean(flt)
  );

  sup_state_e state_q, state_d;
  logic       guard_en, bo_en, ovp_trip, lat_trip, bo_trip, fault_now;

  assign guard_en  = (state_q == S_START) || (state_q == S_RUN) || (state_q == S_BOWAIT);
  assign bo_en     = (state_q == S_RUN);
  assign fault_now = ovp_trip || lat_trip;

  persist_timer #(.CYC(FILT_CYC)) u_ovp_filt (
    .clk(clk), .rst(rst), .en(guard_en), .cond(flt[F_OVP]), .trip(ovp_trip)
  );
  persist_timer #(.CYC(FILT_CYC)) u_lat_filt (
    .clk(clk), .rst(rst), .en(guard_en), .cond(flt[F_LATLOW]), .trip(lat_trip)
  );
  persist_timer #(.CYC(BO_CYC)) u_bo_timer (
    .clk(clk), .rst(rst), .en(bo_en), .cond(flt[F_LINEBO]), .trip(bo_trip)
  );

  always_comb begin
    state_d = state_q;
    if (state_q != S_OFF && flt[F_STOP]) begin
      state_d = S_OFF;
    end else begin
      unique case (state_q)
        S_OFF:    if (flt[F_START] && !flt[F_STOP]) state_d = S_START;
        S_START:  if (fault_now)        state_d = S_CLAMP;
                  else if (flt[F_LINEBI]) state_d = S_RUN;
        S_RUN:    if (fault_now)        state_d = S_CLAMP;
                  else if (bo_trip)     state_d = S_BOWAIT;
        S_BOWAIT: if (fault_now)        state_d = S_CLAMP;
                  else if (flt[F_LINEBI]) state_d = S_RUN;
        S_CLAMP:  if (flt[F_CLAMP])     state_d = S_HOLD;
        S_HOLD:   state_d = S_HOLD;
        default:  state_d = S_OFF;
      endcase
    end
  end

  band_mode_e band_d;

  always_comb begin
    unique case (state_d)
      S_OFF:    band_d = BAND_FORCE_ON;
      S_START:  band_d = BAND_WIDE;
      S_BOWAIT: band_d = BAND_WIDE;
      S_RUN:    band_d = restart_req ? BAND_WIDE : BAND_FORCE_OFF;
      S_CLAMP:  band_d = BAND_FORCE_OFF;
      S_HOLD:   band_d = BAND_HOLD;
      default:  band_d = BAND_FORCE_ON;
    endcase
  end

  supply_band_reg u_band (
    .clk(clk), .rst(rst), .mode(band_d),
    .wide_lo(flt[F_BANDLO]), .wide_hi(flt[F_START]),
    .hold_lo(flt[F_HOLDLO]), .hold_hi(flt[F_HOLDHI]),
    .src_en(hv_src_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_OFF;
      state_oh      <= 6'b000001;
      pwm_run       <= 1'b0;
      clamp_dis     <= 1'b0;
      fault_latched <= 1'b0;
    end else begin
      state_q       <= state_d;
      state_oh      <= 6'(1) << state_d;
      pwm_run       <= (state_d == S_RUN) && !restart_req;
      clamp_dis     <= (state_d == S_CLAMP);
      fault_latched <= (state_d == S_CLAMP) || (state_d == S_HOLD);
    end
  end

  // R12: status is always one-hot
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);
  // R11: a filtered stop-level flag always lands in OFF with the fault cleared
  a_r11_stop_clears: assert property (@(posedge clk) disable iff (rst)
    flt[F_STOP] |=> (state_oh[0] && !fault_latched && !pwm_run));
  // R9: a latched fault persists until the stop level is seen
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && !flt[F_STOP]) |=> fault_latched);
  // R9: the clamp never runs together with the startup source or without a fault
  a_r9_clamp_safe: assert property (@(posedge clk) disable iff (rst)
    clamp_dis |-> (!hv_src_en && fault_latched && !pwm_run));
  // R9: once in hold the clamp is not driven again
  a_r9_clamp_once: assert property (@(posedge clk) disable iff (rst)
    state_oh[5] |=> !clamp_dis);
  // R2: the startup source is off while switching
  a_r2_run_src_off: assert property (@(posedge clk) disable iff (rst)
    pwm_run |-> (!hv_src_en && state_oh[2]));
endmodule

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;
  localparam int FILT = 20;
  localparam int BO   = 40;
  localparam int ST   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic vcc_ge_start = 0, vcc_le_stop = 1, vcc_ge_ovp = 0, vcc_le_clamp = 1;
  logic vcc_le_band_lo = 1, vcc_le_hold_lo = 1, vcc_ge_hold_hi = 0;
  logic line_ge_bi = 0, line_le_bo = 1, lat_pin_low = 0, restart_req = 0;
  logic hv_src_en, clamp_dis, pwm_run, fault_latched;
  logic [5:0] state_oh;

  supply_supervisor #(.FILT_CYC(FILT), .BO_CYC(BO)) uut (
    .clk(clk), .rst(rst),
    .vcc_ge_start(vcc_ge_start), .vcc_le_stop(vcc_le_stop), .vcc_ge_ovp(vcc_ge_ovp),
    .vcc_le_clamp(vcc_le_clamp), .vcc_le_band_lo(vcc_le_band_lo),
    .vcc_le_hold_lo(vcc_le_hold_lo), .vcc_ge_hold_hi(vcc_ge_hold_hi),
    .line_ge_bi(line_ge_bi), .line_le_bo(line_le_bo), .lat_pin_low(lat_pin_low),
    .restart_req(restart_req), .hv_src_en(hv_src_en), .clamp_dis(clamp_dis),
    .pwm_run(pwm_run), .fault_latched(fault_latched), .state_oh(state_oh)
  );

  typedef struct {
    string      tag;
    logic [5:0] st;
    logic       src, clamp, run, flt;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // state indices per R12
  localparam int OFF = 0, STARTUP = 1, RUN = 2, BOWAIT = 3, LCLAMP = 4, LHOLD = 5;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int st, input bit src,
                            input bit clamp, input bit run, input bit flt);
    exp_t e;
    e.tag = tag; e.st = 6'(1) << st; e.src = src; e.clamp = clamp; e.run = run; e.flt = flt;
    q.push_back(e);
  endtask

  // rail level in tenths of a volt
  task automatic vcc(input int dv);
    vcc_ge_start   = (dv >= 180);
    vcc_le_stop    = (dv <= 98);
    vcc_ge_ovp     = (dv > 260);
    vcc_le_clamp   = (dv <= 145);
    vcc_le_band_lo = (dv <= 155);
    vcc_le_hold_lo = (dv <= 120);
    vcc_ge_hold_hi = (dv >= 130);
  endtask

  task automatic line(input int v);
    line_ge_bi = (v >= 104);
    line_le_bo = (v <= 99);
  endtask

  // scoreboard monitor: compares queued expectations away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (state_oh !== e.st || hv_src_en !== e.src || clamp_dis !== e.clamp ||
            pwm_run !== e.run || fault_latched !== e.flt) begin
          bad++;
          $display("FAIL %s: got st=%b src=%b clamp=%b run=%b flt=%b exp st=%b src=%b clamp=%b run=%b flt=%b",
                   e.tag, state_oh, hv_src_en, clamp_dis, pwm_run, fault_latched,
                   e.st, e.src, e.clamp, e.run, e.flt);
        end
      end
    end
  end

  initial begin
    tick(100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    expect_out("R1 reset state", OFF, 1, 0, 0, 0);
    line(0);
    vcc(100); tick(ST);
    expect_out("R2 below start stays off", OFF, 1, 0, 0, 0);
    vcc(185); tick(ST);
    expect_out("R3 startup waits for line", STARTUP, 0, 0, 0, 0);
    vcc(150); tick(ST);
    expect_out("R5 wide band floor charges", STARTUP, 1, 0, 0, 0);
    vcc(170); tick(ST);
    expect_out("R5 wide band holds inside", STARTUP, 1, 0, 0, 0);
    vcc(185); tick(ST);
    expect_out("R5 wide band ceiling stops", STARTUP, 0, 0, 0, 0);
    line(110); tick(ST);
    expect_out("R2 run after brown-in", RUN, 0, 0, 1, 0);

    vcc_le_stop = 1'b1; tick(1); vcc_le_stop = 1'b0; tick(ST);
    expect_out("R13 one-clock stop glitch ignored", RUN, 0, 0, 1, 0);

    line(95); tick(20); line(110); tick(ST);
    expect_out("R4 short sag ignored", RUN, 0, 0, 1, 0);
    line(95); tick(BO + 12);
    expect_out("R4 long sag suspends", BOWAIT, 0, 0, 0, 0);
    vcc(150); tick(ST);
    expect_out("R5 brown-out band charges", BOWAIT, 1, 0, 0, 0);
    vcc(185); tick(ST);
    line(110); tick(ST);
    expect_out("R4 brown-in resumes", RUN, 0, 0, 1, 0);

    restart_req = 1'b1; tick(ST);
    expect_out("R6 restart wait pauses", RUN, 0, 0, 0, 0);
    vcc(150); tick(ST);
    expect_out("R6 restart wait wide band", RUN, 1, 0, 0, 0);
    vcc(185); tick(ST);
    restart_req = 1'b0; tick(ST);
    expect_out("R6 restart release", RUN, 0, 0, 1, 0);

    vcc(265); tick(10); vcc(185); tick(ST);
    expect_out("R7 short overvoltage ignored", RUN, 0, 0, 1, 0);
    vcc(265); tick(FILT + 12);
    expect_out("R7 R9 overvoltage latches with clamp", LCLAMP, 0, 1, 0, 1);
    vcc(140); tick(ST);
    expect_out("R9 clamp ends in hold", LHOLD, 0, 0, 0, 1);
    vcc(120); tick(ST);
    expect_out("R10 hold floor charges", LHOLD, 1, 0, 0, 1);
    vcc(125); tick(ST);
    expect_out("R10 hold inside keeps", LHOLD, 1, 0, 0, 1);
    vcc(135); tick(ST);
    expect_out("R10 hold ceiling stops", LHOLD, 0, 0, 0, 1);
    vcc(150); tick(ST);
    expect_out("R9 clamp not repeated", LHOLD, 0, 0, 0, 1);

    vcc(90); tick(ST);
    expect_out("R11 stop level clears fault", OFF, 1, 0, 0, 0);
    lat_pin_low = 1'b1; tick(FILT + 12);
    expect_out("R11 fault ignored in off", OFF, 1, 0, 0, 0);
    lat_pin_low = 1'b0; tick(ST);

    vcc(185); line(110); tick(2 * ST);
    expect_out("R2 restart to run", RUN, 0, 0, 1, 0);
    lat_pin_low = 1'b1; tick(10); lat_pin_low = 1'b0; tick(ST);
    expect_out("R8 short pin low ignored", RUN, 0, 0, 1, 0);
    lat_pin_low = 1'b1; tick(FILT + 12);
    expect_out("R8 pin low latches", LCLAMP, 0, 1, 0, 1);
    lat_pin_low = 1'b0;
    vcc(90); tick(ST);
    expect_out("R11 stop beats clamp end", OFF, 1, 0, 0, 0);

    tick(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule